// File: doc/BRIEF.md
# Parity-Predicted MixColumns Column Unit

This unit applies the AES MixColumns transform to one four-byte state column. Every byte travels with an even parity bit. Next to the transform, the unit computes the parity of each result byte in closed form. It uses only the incoming parity bits and the top bit of each incoming byte, so it never builds a second copy of the transform. One cycle after a valid column arrives, the unit does three things:

- It presents the transformed bytes and the predicted parity bits.
- It rebuilds the parity of each result byte from the result data.
- It raises an error flag if any rebuilt parity disagrees with its prediction.

A wrong input parity bit is carried into the prediction and therefore reaches the flag. This holds whether the data byte was hit or its parity bit was hit. A test-only mask input XORs chosen bits into the result data just before the register, which lets a bench inject an output fault and confirm that the check catches it.

Top module: `mixcol_parity_guard`

## Requirements
- R1: While reset is asserted, and until the first accepted column after release, `out_valid`, `err`, `out_col` and `out_par` are all zero.
- R2: One cycle after `in_valid` is high, `out_col` holds the MixColumns result of `in_col` XOR `flip_mask`, with no carries and polynomial 0x11B. Row k is bits 8k+7..8k, and result row r = 2·s[r] ^ 3·s[r+1] ^ s[r+2] ^ s[r+3], with indices taken mod 4.
- R3: One cycle after `in_valid`, `out_par[r]` equals the XOR of:
  - `in_par` at rows r, r+2 and r+3;
  - bit 7 of input rows r and r+1 (indices mod 4).
- R4: `out_valid` equals the value of `in_valid` one cycle earlier.
- R5: `err` is low in every cycle in which `out_valid` is low.
- R6: A column with every `in_par[k]` equal to the XOR of the 8 bits of row k, and with `flip_mask` zero, yields `err` low in the following cycle.
- R7: With `flip_mask` zero, a column in which exactly one row's parity bit disagrees with its data raises `err` in the following cycle. It does not matter whether the data or the parity bit was corrupted.
- R8: With consistent input parity, a `flip_mask` with exactly one bit set raises `err` in the following cycle, and `out_col` shows that bit inverted relative to the fault-free result.
- R9: In a cycle where `in_valid` is low, `out_col` and `out_par` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Column strobe |
| in_col | input | 32 | Input column, row k in bits 8k+7..8k |
| in_par | input | 4 | Even parity bit per input row |
| flip_mask | input | 32 | Test-only XOR mask on result data before the check |
| out_col | output | 32 | Transformed column |
| out_par | output | 4 | Predicted parity per result row |
| out_valid | output | 1 | Result strobe |
| err | output | 1 | Parity mismatch flag, qualified by out_valid |

## Verification
A wrong transform coefficient or a wrong row rotation changes `out_col` in the cycle after the strobe. Such a fault also trips `err` in that same cycle, because the predicted parity no longer matches the wrong data. A wrong term in a prediction equation shows directly as an `out_par` value that differs from the parity of the correct result. It also gives a false alarm on clean input, again one cycle after the strobe. A broken compare or broken gating shows either as a missed fault under a single flipped parity bit or mask bit, or as a flag raised while `out_valid` is low.

// File: rtl/mcpg_pkg.sv
package mcpg_pkg;
  localparam int ROWS   = 4;
  localparam int BW     = 8;
  localparam int COL_W  = ROWS * BW;
  localparam logic [BW-1:0] RED_LO = 8'h1B;

  function automatic logic [BW-1:0] xt2(input logic [BW-1:0] b);
    xt2 = {b[BW-2:0], 1'b0} ^ (b[BW-1] ? RED_LO : '0);
  endfunction
endpackage

// File: rtl/mcpg_mix.sv
module mcpg_mix
  import mcpg_pkg::*;
(
  input  logic [COL_W-1:0] col_i,
  output logic [COL_W-1:0] col_o
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    logic [BW-1:0] a, b, c, d;
    assign a = col_i[BW*r +: BW];
    assign b = col_i[BW*((r+1)%ROWS) +: BW];
    assign c = col_i[BW*((r+2)%ROWS) +: BW];
    assign d = col_i[BW*((r+3)%ROWS) +: BW];
    assign col_o[BW*r +: BW] = xt2(a) ^ xt2(b) ^ b ^ c ^ d;
  end
endmodule

// File: rtl/mcpg_predict.sv
module mcpg_predict
  import mcpg_pkg::*;
(
  input  logic [COL_W-1:0] col_i,
  input  logic [ROWS-1:0]  par_i,
  output logic [ROWS-1:0]  par_o
);
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign par_o[r] = par_i[r] ^ par_i[(r+2)%ROWS] ^ par_i[(r+3)%ROWS]
                    ^ col_i[BW*r + BW-1] ^ col_i[BW*((r+1)%ROWS) + BW-1];
  end
endmodule

// File: rtl/mcpg_check.sv
module mcpg_check
  import mcpg_pkg::*;
(
  input  logic [COL_W-1:0] col_i,
  input  logic [ROWS-1:0]  pred_i,
  input  logic             en_i,
  output logic             err_o
);
  logic [ROWS-1:0] regen;
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign regen[r] = ^col_i[BW*r +: BW];
  end
  assign err_o = en_i & (|(regen ^ pred_i));
endmodule

// File: rtl/mixcol_parity_guard.sv
module mixcol_parity_guard
  import mcpg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [COL_W-1:0] in_col,
  input  logic [ROWS-1:0]  in_par,
  input  logic [COL_W-1:0] flip_mask,
  output logic [COL_W-1:0] out_col,
  output logic [ROWS-1:0]  out_par,
  output logic             out_valid,
  output logic             err
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic [COL_W-1:0] mixed;
  logic [ROWS-1:0]  pred;
  logic [COL_W-1:0] col_d, col_q;
  logic [ROWS-1:0]  par_d, par_q;
  logic             vld_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  mcpg_mix     u_mix  (.col_i(in_col), .col_o(mixed));
  mcpg_predict u_pred (.col_i(in_col), .par_i(in_par), .par_o(pred));

  always_comb begin
    col_d = col_q;
    par_d = par_q;
    if (in_valid) begin
      col_d = mixed ^ flip_mask;
      par_d = pred;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      col_q <= '0;
      par_q <= '0;
      vld_q <= 1'b0;
    end else begin
      col_q <= col_d;
      par_q <= par_d;
      vld_q <= in_valid;
    end
  end

  mcpg_check u_chk (.col_i(col_q), .pred_i(par_q), .en_i(vld_q), .err_o(err));

  assign out_col   = col_q;
  assign out_par   = par_q;
  assign out_valid = vld_q;
endmodule

// File: rtl/mixcol_parity_guard_chk.sv
module mixcol_parity_guard_chk
  import mcpg_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic [COL_W-1:0] in_col,
  input logic [ROWS-1:0]  in_par,
  input logic [COL_W-1:0] flip_mask,
  input logic [COL_W-1:0] out_col,
  input logic [ROWS-1:0]  out_par,
  input logic             out_valid,
  input logic             err
);
  logic [ROWS-1:0] in_regen;
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign in_regen[r] = ^in_col[BW*r +: BW];
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R4
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R4
  AST_ERR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !err); // R5
  AST_NO_FALSE_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_regen == in_par && flip_mask == '0) |=> !err); // R6
  AST_PAR_FAULT_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && flip_mask == '0 && $countones(in_regen ^ in_par) == 1) |=> err); // R7
  AST_MASK_FAULT_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_regen == in_par && $countones(flip_mask) == 1) |=> err); // R8
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_col) && $stable(out_par))); // R9
endmodule

bind mixcol_parity_guard mixcol_parity_guard_chk u_assert (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_col(in_col),
  .in_par(in_par), .flip_mask(flip_mask), .out_col(out_col),
  .out_par(out_par), .out_valid(out_valid), .err(err)
);

// File: tb/mixcol_parity_guard_tb.sv
module mixcol_parity_guard_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_col = '0;
  logic [3:0]  in_par = '0;
  logic [31:0] flip_mask = '0;
  logic [31:0] out_col;
  logic [3:0]  out_par;
  logic        out_valid;
  logic        err;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mixcol_parity_guard u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_col(in_col),
    .in_par(in_par), .flip_mask(flip_mask), .out_col(out_col),
    .out_par(out_par), .out_valid(out_valid), .err(err)
  );

  // {input column, expected column}, row 0 in the low byte
  localparam logic [63:0] VEC [6] = '{
    {32'h455313db, 32'hbca14d8e},
    {32'h5c220af2, 32'h9d58dc9f},
    {32'h01010101, 32'h01010101},
    {32'hc6c6c6c6, 32'hc6c6c6c6},
    {32'hd5d4d4d4, 32'hd6d7d5d5},
    {32'h4c31262d, 32'hf8bd7e4d}
  };

  function automatic logic [3:0] bpar(input logic [31:0] c);
    for (int k = 0; k < 4; k++) bpar[k] = ^c[8*k +: 8];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] c, input logic [3:0] p, input logic [31:0] m);
    @(negedge clk);
    in_valid = 1'b1; in_col = c; in_par = p; flip_mask = m;
    @(negedge clk);
    in_valid = 1'b0; flip_mask = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", {31'd0, out_valid}, 32'd0);
    chk("R1 err in reset", {31'd0, err}, 32'd0);
    chk("R1 col in reset", out_col, 32'd0);
    chk("R1 par in reset", {28'd0, out_par}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 col after release", out_col, 32'd0);
    chk("R5 err idle", {31'd0, err}, 32'd0);

    for (int i = 0; i < 6; i++) begin
      send(VEC[i][63:32], bpar(VEC[i][63:32]), '0);
      chk("R2 result", out_col, VEC[i][31:0]);
      chk("R3 predicted parity", {28'd0, out_par}, {28'd0, bpar(VEC[i][31:0])});
      chk("R4 out_valid", {31'd0, out_valid}, 32'd1);
      chk("R6 no alarm", {31'd0, err}, 32'd0);
    end

    // R4 / R5 / R9: one idle cycle keeps result and drops valid
    @(negedge clk);
    chk("R4 valid drops", {31'd0, out_valid}, 32'd0);
    chk("R5 err gated", {31'd0, err}, 32'd0);
    chk("R9 col held", out_col, VEC[5][31:0]);
    chk("R9 par held", {28'd0, out_par}, {28'd0, bpar(VEC[5][31:0])});

    // R7: one parity bit wrong, for each row
    for (int k = 0; k < 4; k++) begin
      send(VEC[0][63:32], bpar(VEC[0][63:32]) ^ (4'b1 << k), '0);
      chk("R7 parity fault flagged", {31'd0, err}, 32'd1);
    end
    // R7: data bit 7 of row 2 flipped, parity kept
    send(VEC[1][63:32] ^ 32'h0080_0000, bpar(VEC[1][63:32]), '0);
    chk("R7 data fault flagged", {31'd0, err}, 32'd1);
    // R7: data bit 0 of row 0 flipped, parity kept
    send(VEC[1][63:32] ^ 32'h1, bpar(VEC[1][63:32]), '0);
    chk("R7 data lsb fault flagged", {31'd0, err}, 32'd1);

    // R8: single mask bit at several positions
    for (int b = 0; b < 32; b += 7) begin
      send(VEC[2][63:32], bpar(VEC[2][63:32]), 32'h1 << b);
      chk("R8 mask fault flagged", {31'd0, err}, 32'd1);
      chk("R8 mask bit visible", out_col, VEC[2][31:0] ^ (32'h1 << b));
    end

    // R6: clean column after faults clears the flag
    send(VEC[3][63:32], bpar(VEC[3][63:32]), '0);
    chk("R6 clean after fault", {31'd0, err}, 32'd0);
    chk("R2 result after fault", out_col, VEC[3][31:0]);

    // R1: reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 col cleared", out_col, 32'd0);
    chk("R1 valid cleared", {31'd0, out_valid}, 32'd0);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule